// File: doc/BRIEF.md
# Deglitched Dual-Comparator Pulse Recognizer

This block sits behind an analog window comparator and decides when a motion event has occurred. It receives two asynchronous comparator levels: one that goes high when the signal crosses the upper threshold, and one that goes high when the signal crosses the lower threshold. Each level passes through its own synchronizer and width qualifier, which runs on a slow system clock. The qualifier removes short glitches and reports each accepted pulse once.

A mode input selects how qualified pulses are matched. In single-pulse mode, any accepted pulse on either comparator is a detection. In dual-pulse mode, an accepted pulse on one comparator must be followed by an accepted pulse on the other comparator within a fixed window. When the block detects motion, it drives a fixed-length output pulse. A gate input from the warm-up sequencer holds the output low and keeps the recognizer idle until the analog front end has settled.

Top module: `pulse_recognizer`

## Requirements
- R1: A comparator level that is high on only 2 consecutive clock edges is discarded and causes no output pulse.
- R2: A comparator level that is high on 3 consecutive clock edges (edges s, s+1, s+2) is accepted. In single-pulse mode `motion_o` is high after edge s+4, so it first reads high in the cycle after that edge.
- R3: With `dual_mode_i` = 0 (single-pulse mode), one accepted pulse on either `cmp_hi_i` or `cmp_lo_i` triggers the output.
- R4: With `dual_mode_i` = 1 (dual-pulse mode), detection requires one accepted pulse from each comparator, in either order. A lone pulse never triggers.
- R5: In dual-pulse mode, the second pulse is accepted when its acceptance edge is at most 312 cycles after the first pulse's acceptance edge. At 313 cycles the first pulse is dropped and no output results.
- R6: In dual-pulse mode, a second accepted pulse from the same comparator replaces the first one and restarts the 312-cycle window.
- R7: Once triggered, `motion_o` stays high for exactly 120 consecutive cycles and then returns low.
- R8: Accepted pulses that arrive while `motion_o` is high are ignored. Recognition starts again from idle once the pulse ends.
- R9: While `warm_ok_i` is low, `motion_o` is low. It goes low in the same cycle that `warm_ok_i` falls, and a pulse cut short this way does not resume.
- R10: After a synchronous active-low reset, `motion_o` is low, even when the reset interrupts a running pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warm_ok_i | input | 1 | Warm-up done gate; 0 holds the output low |
| dual_mode_i | input | 1 | 0 = single-pulse mode, 1 = dual-pulse mode |
| cmp_hi_i | input | 1 | Asynchronous upper-threshold comparator level |
| cmp_lo_i | input | 1 | Asynchronous lower-threshold comparator level |
| motion_o | output | 1 | Motion detected pulse, 120 cycles long |

## Verification
Take the edge at which a comparator level is first sampled high as edge s. The output rises after edge s+4: two synchronizer stages, three qualifying samples, and one register in the pulse timer. The bench drives and samples at falling edges, so the first high reading of `motion_o` is expected at iteration s+5. The window limit is checked at delays of exactly 312 and 313 cycles between the two pulse starts. Each vector records the first iteration at which the output is high and the total number of high iterations. Both are compared with values worked out from these latencies, so a one-cycle shift in any stage shows up as a failure. The gate test samples 1 ns after the gate falls, because the drop to low is required within the same cycle.

// File: rtl/prc_pkg.sv
// Shared types for the pulse recognizer.
// Assumes: used by pr_matcher and visible to the bench only through ports.
package prc_pkg;

    // Matching state: idle, or holding a first pulse from one comparator.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM_HI = 2'd1,
        ST_ARM_LO = 2'd2
    } rec_state_e;

endpackage

// File: rtl/pr_deglitch.sv
// Synchronizes one asynchronous comparator level and qualifies its width.
// A one-cycle valid_o strobe is raised once the synchronized level has been
// high for QUAL_CYCLES consecutive samples; it re-arms only after the level
// goes low again. Assumes SYNC_STAGES >= 2 and QUAL_CYCLES >= 1.
module pr_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic valid_o
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   level;

    assign level = sync_q[SYNC_STAGES-1];

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Count consecutive high samples, saturating once the pulse qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n)                        run_q <= '0;
        else if (!level)                   run_q <= '0;
        else if (run_q != CW'(QUAL_CYCLES)) run_q <= run_q + 1'b1;
    end

    assign valid_o = level && (run_q == CW'(QUAL_CYCLES - 1));

endmodule

// File: rtl/pr_matcher.sv
// Matches qualified pulse strobes into a detection request (fire_o, combinational).
// Single mode: any strobe fires. Dual mode: a strobe from one comparator arms,
// and a strobe from the other within WINDOW_CYCLES fires; a repeat from the
// armed comparator re-arms. clear_i forces idle and suppresses fire_o.
module pr_matcher
    import prc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 312
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic dual_i,
    input  logic hit_hi_i,
    input  logic hit_lo_i,
    output logic fire_o
);
    localparam int TW = $clog2(WINDOW_CYCLES + 1);

    rec_state_e    state_q;
    logic [TW-1:0] timer_q;
    logic          expired;

    assign expired = (timer_q == TW'(WINDOW_CYCLES));

    // Decide whether the present strobes complete a detection.
    always_comb begin
        fire_o = 1'b0;
        if (!clear_i) begin
            if (!dual_i) begin
                fire_o = hit_hi_i || hit_lo_i;
            end else begin
                unique case (state_q)
                    ST_IDLE:   fire_o = hit_hi_i && hit_lo_i;
                    ST_ARM_HI: fire_o = hit_lo_i;
                    ST_ARM_LO: fire_o = hit_hi_i;
                    default:   fire_o = 1'b0;
                endcase
            end
        end
    end

    // Track the armed comparator and the age of its pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || fire_o) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hit_hi_i) begin
                        state_q <= ST_ARM_HI;
                        timer_q <= TW'(1);
                    end else if (hit_lo_i) begin
                        state_q <= ST_ARM_LO;
                        timer_q <= TW'(1);
                    end
                end
                ST_ARM_HI, ST_ARM_LO: begin
                    if ((state_q == ST_ARM_HI && hit_hi_i) ||
                        (state_q == ST_ARM_LO && hit_lo_i)) begin
                        timer_q <= TW'(1);
                    end else if (expired) begin
                        state_q <= ST_IDLE;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    timer_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pr_out_timer.sv
// Produces the fixed-length detection pulse. A fire request while idle loads
// OUT_CYCLES; requests while busy are dropped. A low gate clears the count and
// masks the output in the same cycle.
module pr_out_timer #(
    parameter int OUT_CYCLES = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic fire_i,
    output logic busy_o,
    output logic pulse_o
);
    localparam int OW = $clog2(OUT_CYCLES + 1);

    logic [OW-1:0] left_q;

    // Load on an accepted request, then count the pulse down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_i)           left_q <= '0;
        else if (fire_i && left_q == '0) left_q <= OW'(OUT_CYCLES);
        else if (left_q != '0)           left_q <= left_q - 1'b1;
    end

    assign busy_o  = (left_q != '0);
    assign pulse_o = busy_o && gate_i;

endmodule

// File: rtl/pulse_recognizer.sv
// Top: two comparator qualifiers, a pulse matcher and an output pulse timer.
// Assumes the comparator inputs are asynchronous levels and the clock is the
// slow system oscillator. Index 0 is the upper-threshold channel, index 1 the lower.
module pulse_recognizer #(
    parameter int SYNC_STAGES   = 2,
    parameter int QUAL_CYCLES   = 3,
    parameter int WINDOW_CYCLES = 312,
    parameter int OUT_CYCLES    = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_ok_i,
    input  logic dual_mode_i,
    input  logic cmp_hi_i,
    input  logic cmp_lo_i,
    output logic motion_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_vec;
    logic [NCH-1:0] hits;
    logic           fire;
    logic           busy;
    logic           hold;

    assign raw_vec = {cmp_lo_i, cmp_hi_i};
    assign hold    = busy || !warm_ok_i;

    // One synchronizer and width qualifier per comparator channel.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pr_deglitch #(
            .SYNC_STAGES(SYNC_STAGES),
            .QUAL_CYCLES(QUAL_CYCLES)
        ) u_dg (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_vec[ch]),
            .valid_o(hits[ch])
        );
    end

    pr_matcher #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (hold),
        .dual_i  (dual_mode_i),
        .hit_hi_i(hits[0]),
        .hit_lo_i(hits[1]),
        .fire_o  (fire)
    );

    pr_out_timer #(
        .OUT_CYCLES(OUT_CYCLES)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (warm_ok_i),
        .fire_i (fire),
        .busy_o (busy),
        .pulse_o(motion_o)
    );

endmodule

// File: rtl/pr_checker.sv
// Property checker for pulse_recognizer, attached by bind below.
// Assumes the upper/lower channel ordering of the top module's vectors.
module pr_checker #(
    parameter int OUT_CYCLES = 120
) (
    input logic       clk,
    input logic       rst_n,
    input logic       gate_i,
    input logic       out_i,
    input logic [1:0] hit_i,
    input logic [1:0] raw_i
);
    localparam int LW = $clog2(OUT_CYCLES + 2);

    logic [LW-1:0] hi_len;

    // Count how many cycles the output has been high so far.
    always_ff @(posedge clk) begin
        if (!rst_n || !out_i) hi_len <= '0;
        else                  hi_len <= hi_len + 1'b1;
    end

    // R9
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |-> !out_i);

    // R2
    hi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i[0] |-> ($past(raw_i[0], 2) && $past(raw_i[0], 3) && $past(raw_i[0], 4)));

    // R1
    lo_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i[1] |-> ($past(raw_i[1], 2) && $past(raw_i[1], 3) && $past(raw_i[1], 4)));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i[0] |=> !hit_i[0]);

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_i) |-> $past(hit_i != 2'b00));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_i) && gate_i && $past(gate_i) && $past(rst_n)) |-> (hi_len == LW'(OUT_CYCLES)));

    // R8
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_i |-> (hi_len < LW'(OUT_CYCLES)));

endmodule

bind pulse_recognizer pr_checker #(
    .OUT_CYCLES(OUT_CYCLES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .gate_i(warm_ok_i),
    .out_i (motion_o),
    .hit_i (hits),
    .raw_i (raw_vec)
);

// File: tb/tb_pulse_recognizer.sv
`timescale 1ns/1ps
module tb_pulse_recognizer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic warm_ok_i = 1'b1;
    logic dual_mode_i = 1'b0;
    logic cmp_hi_i = 1'b0;
    logic cmp_lo_i = 1'b0;
    logic motion_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pulse_recognizer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_ok_i  (warm_ok_i),
        .dual_mode_i(dual_mode_i),
        .cmp_hi_i   (cmp_hi_i),
        .cmp_lo_i   (cmp_lo_i),
        .motion_o   (motion_o)
    );

    // Fields: mode, hi1 start, hi1 len, hi2 start, hi2 len, lo start, lo len,
    // expected first high iteration (-1 none), expected high iterations.
    localparam int NV = 12;
    localparam int RUN = 600;
    localparam int VEC [NV][9] = '{
        '{0,   2, 3,   0, 0,   0, 0,   7, 120},  // R2 R3 hi accepted at 3
        '{0,   2, 2,   0, 0,   0, 0,  -1,   0},  // R1 2-cycle glitch
        '{0,   0, 0,   0, 0,   4, 5,   9, 120},  // R3 lo only
        '{1,   2, 4,   0, 0,   0, 0,  -1,   0},  // R4 lone hi in dual
        '{1,   2, 4,   0, 0, 100, 4, 105, 120},  // R4 hi then lo
        '{1,   0, 0,   0, 0,   2, 4,  -1,   0},  // R4 lone lo in dual
        '{1,   2, 4,   0, 0, 314, 4, 319, 120},  // R5 gap 312
        '{1,   2, 4,   0, 0, 315, 4,  -1,   0},  // R5 gap 313
        '{1,   2, 4, 100, 4, 400, 4, 405, 120},  // R6 re-arm on repeat
        '{1,   2, 4,   0, 0,  50, 2,  -1,   0},  // R1 glitch as second pulse
        '{0,   2, 3,   0, 0,  60, 3,   7, 120},  // R8 ignored while busy
        '{0,   2, 3,   0, 0, 200, 3,   7, 240}   // R8 resumes after pulse
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmp_hi_i = 1'b0;
        cmp_lo_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int first;
        int highs;
        do_reset();
        // R10 reset state
        check(motion_o == 1'b0, "R10 reset state", int'(motion_o), 0);

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            dual_mode_i = VEC[v][0][0];
            first = -1;
            highs = 0;
            for (int c = 0; c < RUN; c++) begin
                @(negedge clk);
                if (motion_o && first < 0) first = c;
                if (motion_o) highs++;
                cmp_hi_i = (c >= VEC[v][1] && c < VEC[v][1] + VEC[v][2]) ||
                           (c >= VEC[v][3] && c < VEC[v][3] + VEC[v][4]);
                cmp_lo_i = (c >= VEC[v][5] && c < VEC[v][5] + VEC[v][6]);
            end
            check(first == VEC[v][7], $sformatf("R2/R5 vector %0d rise", v), first, VEC[v][7]);
            check(highs == VEC[v][8], $sformatf("R7/R8 vector %0d high count", v), highs, VEC[v][8]);
        end

        // R9: gate low throughout blocks detection.
        do_reset();
        dual_mode_i = 1'b0;
        warm_ok_i = 1'b0;
        highs = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (motion_o) highs++;
            cmp_hi_i = (c >= 2 && c < 6);
        end
        check(highs == 0, "R9 gated pulse", highs, 0);

        // R9: gate falling mid-pulse masks the output in the same cycle.
        warm_ok_i = 1'b1;
        do_reset();
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            cmp_hi_i = (c >= 2 && c < 5);
        end
        check(motion_o == 1'b1, "R7 pulse running", int'(motion_o), 1);
        warm_ok_i = 1'b0;
        #1;
        check(motion_o == 1'b0, "R9 immediate mask", int'(motion_o), 0);
        repeat (3) @(negedge clk);
        warm_ok_i = 1'b1;
        highs = 0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (motion_o) highs++;
        end
        check(highs == 0, "R9 no resume after gate", highs, 0);

        // R10: reset interrupting a running pulse.
        do_reset();
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            cmp_lo_i = (c >= 2 && c < 6);
        end
        check(motion_o == 1'b1, "R3 lo pulse running", int'(motion_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(motion_o == 1'b0, "R10 reset mid-pulse", int'(motion_o), 0);
        rst_n = 1'b1;
        highs = 0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (motion_o) highs++;
        end
        check(highs == 0, "R10 stays low after reset", highs, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule